// File: doc/BRIEF.md
# Serial to I/Q Bit Splitter

This block turns a serial bit stream into the two parallel channels that a quadrature modulator needs. The bits arrive on a single data line. A one-cycle enable marks each bit period, all within one system clock domain. The block groups the bits into consecutive pairs (dibits). The earlier bit of each pair goes to the quadrature channel and the later bit goes to the in-phase channel.

The two channel bits are loaded together, one clock after the second bit of a pair has been shifted in. This way the block only ever captures settled shift-register contents. The two bits then hold until the next pair is complete, so each channel runs at half the serial bit rate. For each channel the block also drives a signed two's-complement level, +1 or −1, which a downstream mixer can multiply against a carrier. A single-cycle strobe marks every new pair.

Carrier generation, mixing and filtering are handled elsewhere. The block only shifts, tracks the dibit phase, holds the pair and maps each bit to a level.

Top module: `qpsk_bit_splitter`

## Requirements
- R1: A bit is accepted only in a cycle where `bit_en` is 1. In cycles where `bit_en` is 0, changes on `bit_in` have no effect on any output.
- R2: Accepted bits are paired in arrival order, starting at the first bit accepted after reset. The first bit of each pair appears on `q_bit` and the second on `i_bit`.
- R3: If the second bit of a pair is accepted at clock edge E, then `i_bit`, `q_bit`, both levels and `symbol_valid` show the new pair from clock edge E+1 onward.
- R4: `symbol_valid` is 1 for exactly one clock cycle for each completed pair. It is never 1 in two consecutive cycles.
- R5: Outside the cycle in which `symbol_valid` is 1, `i_bit` and `q_bit` keep their previous values. Each channel value therefore lasts two bit periods.
- R6: Each level output is a LEVEL_W-bit signed two's-complement value. It is +1 when the matching channel bit is 1 and −1 (all ones) when that bit is 0.
- R7: A synchronous active-high `rst` clears the shift stages and the pair phase, drives both channel bits to 0 (both levels −1) and drives `symbol_valid` to 0. A half-received pair is discarded, and the next accepted bit starts a new pair.
- R8: `bit_en` may be 1 on every clock cycle. Every pair is still delivered with the latency given in R3, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-period enable; `bit_in` is accepted in a cycle where this is 1 |
| bit_in | input | 1 | Serial data bit |
| i_bit | output | 1 | In-phase channel bit (second bit of the pair) |
| q_bit | output | 1 | Quadrature channel bit (first bit of the pair) |
| i_level | output | LEVEL_W | Signed level for the in-phase channel |
| q_level | output | LEVEL_W | Signed level for the quadrature channel |
| symbol_valid | output | 1 | One-cycle strobe when a new pair is loaded |

## Verification
The assertions check the following on every cycle:
- the strobe is a single cycle wide;
- the channel bits are held when no strobe is present;
- each level agrees with its bit;
- the strobe always comes two edges after an accepted bit;
- the reset values take effect.

Only the bench scenarios can show which bit lands on which channel, and that the latency is exact. The bench feeds repeating 100 and 110 streams with wide gaps and with back-to-back enables, and it toggles `bit_in` between enables. The bench also covers the recovery after a reset that arrives midway through a pair.

// File: rtl/qsplit_pkg.sv
package qsplit_pkg;

    // number of serial bits folded into one symbol
    localparam int PAIR_BITS = 2;

    // channel indices inside the per-channel arrays of the top level
    localparam int CH_I     = 0;
    localparam int CH_Q     = 1;
    localparam int NUM_CH   = 2;

    // which half of the current pair the next accepted bit fills
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pair_phase_t;

    // one captured symbol, quadrature bit arrived first
    typedef struct packed {
        logic q;
        logic i;
    } dibit_t;

    localparam dibit_t DIBIT_RESET = '{q: 1'b0, i: 1'b0};

    // split a shift-register snapshot (older bit in the upper position)
    function automatic dibit_t split_pair(input logic [PAIR_BITS-1:0] sr);
        dibit_t d;
        d.q = sr[PAIR_BITS-1];
        d.i = sr[0];
        return d;
    endfunction

endpackage

// File: rtl/qsplit_shifter.sv
module qsplit_shifter
    import qsplit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_en,
    input  logic   bit_in,
    output dibit_t pair,
    output logic   pair_ready
);

    logic [PAIR_BITS-1:0] stage_q;
    pair_phase_t          phase_q;

    // two-stage shift register, advanced only on the bit-period enable
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (bit_en) begin
            stage_q <= {stage_q[PAIR_BITS-2:0], bit_in};
        end
    end

    // dibit phase toggle: divides the bit rate by two
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_FIRST;
            pair_ready <= 1'b0;
        end else begin
            pair_ready <= bit_en && (phase_q == PH_SECOND);
            if (bit_en) begin
                phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
            end
        end
    end

    assign pair = split_pair(stage_q);

endmodule

// File: rtl/qsplit_capture.sv
module qsplit_capture
    import qsplit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pair_ready,
    input  dibit_t pair_in,
    output dibit_t pair_out,
    output logic   strobe
);

    // loads one edge after the shift stage, so it reads settled contents
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_out <= DIBIT_RESET;
            strobe   <= 1'b0;
        end else begin
            strobe <= pair_ready;
            if (pair_ready) begin
                pair_out <= pair_in;
            end
        end
    end

endmodule

// File: rtl/qsplit_level_map.sv
module qsplit_level_map #(
    parameter int LEVEL_W = 2
) (
    input  logic                      bit_val,
    output logic signed [LEVEL_W-1:0] level
);

    localparam logic [LEVEL_W-1:0] LVL_POS = LEVEL_W'(1);
    localparam logic [LEVEL_W-1:0] LVL_NEG = {LEVEL_W{1'b1}};

    // unipolar to bipolar: 1 -> +1, 0 -> -1
    always_comb begin
        level = bit_val ? LVL_POS : LVL_NEG;
    end

endmodule

// File: rtl/qpsk_bit_splitter.sv
module qpsk_bit_splitter
    import qsplit_pkg::*;
#(
    parameter int LEVEL_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bit_en,
    input  logic                      bit_in,
    output logic                      i_bit,
    output logic                      q_bit,
    output logic signed [LEVEL_W-1:0] i_level,
    output logic signed [LEVEL_W-1:0] q_level,
    output logic                      symbol_valid
);

    dibit_t shift_pair;
    dibit_t held_pair;
    logic   pair_ready;

    logic [NUM_CH-1:0]         ch_bit;
    logic signed [LEVEL_W-1:0] ch_level [NUM_CH];

    qsplit_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .pair      (shift_pair),
        .pair_ready(pair_ready)
    );

    qsplit_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .pair_ready(pair_ready),
        .pair_in   (shift_pair),
        .pair_out  (held_pair),
        .strobe    (symbol_valid)
    );

    assign ch_bit[CH_I] = held_pair.i;
    assign ch_bit[CH_Q] = held_pair.q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        qsplit_level_map #(.LEVEL_W(LEVEL_W)) u_map (
            .bit_val(ch_bit[g]),
            .level  (ch_level[g])
        );
    end

    assign i_bit   = ch_bit[CH_I];
    assign q_bit   = ch_bit[CH_Q];
    assign i_level = ch_level[CH_I];
    assign q_level = ch_level[CH_Q];

endmodule

// File: rtl/qpsk_bit_splitter_chk.sv
module qpsk_bit_splitter_chk #(
    parameter int LEVEL_W = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bit_en,
    input logic                      bit_in,
    input logic                      i_bit,
    input logic                      q_bit,
    input logic signed [LEVEL_W-1:0] i_level,
    input logic signed [LEVEL_W-1:0] q_level,
    input logic                      symbol_valid
);

    localparam logic [LEVEL_W-1:0] POS = LEVEL_W'(1);
    localparam logic [LEVEL_W-1:0] NEG = {LEVEL_W{1'b1}};

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        symbol_valid |=> !symbol_valid);                                     // R4

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !symbol_valid |-> ($stable(i_bit) && $stable(q_bit)));               // R5

    AST_I_LEVEL_MAP: assert property (@(posedge clk) disable iff (rst)
        i_level == (i_bit ? POS : NEG));                                     // R6

    AST_Q_LEVEL_MAP: assert property (@(posedge clk) disable iff (rst)
        q_level == (q_bit ? POS : NEG));                                     // R6

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        symbol_valid |-> $past(bit_en, 2));                                  // R3

    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (!symbol_valid && !i_bit && !q_bit && i_level == NEG && q_level == NEG)); // R7

endmodule

bind qpsk_bit_splitter qpsk_bit_splitter_chk #(.LEVEL_W(LEVEL_W)) u_chk (.*);

// File: tb/qpsk_bit_splitter_test.sv
module qpsk_bit_splitter_test;

    localparam int LW       = 2;
    localparam int WDOG_MAX = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic i_bit, q_bit, symbol_valid;
    logic signed [LW-1:0] i_level, q_level;

    int checks = 0;
    int errors = 0;
    int edge_cnt = 0;
    bit done = 1'b0;

    // expected item: {deadline edge count, q, i}
    typedef struct {
        int   at_edge;
        logic q;
        logic i;
    } exp_t;
    exp_t sb[$];

    logic have_first = 1'b0;
    logic first_bit  = 1'b0;
    logic last_i = 1'b0;
    logic last_q = 1'b0;

    qpsk_bit_splitter #(.LEVEL_W(LW)) uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .i_bit(i_bit), .q_bit(q_bit), .i_level(i_level), .q_level(q_level),
        .symbol_valid(symbol_valid)
    );

    always #5 clk = ~clk;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive one accepted bit, then idle cycles with a toggling bit_in (R1 noise)
    task automatic send_bit(input logic b, input int idle);
        bit_en = 1'b1;
        bit_in = b;
        if (have_first) begin
            sb.push_back('{at_edge: edge_cnt + 2, q: first_bit, i: b});
            have_first = 1'b0;
        end else begin
            first_bit  = b;
            have_first = 1'b1;
        end
        @(negedge clk);
        for (int k = 0; k < idle; k++) begin
            bit_en = 1'b0;
            bit_in = ~bit_in;
            @(negedge clk);
        end
        bit_en = 1'b0;
    endtask

    task automatic send_pattern(input logic [2:0] pat, input int reps, input int idle);
        for (int r = 0; r < reps; r++) begin
            for (int k = 2; k >= 0; k--) send_bit(pat[k], idle);
        end
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R4", "pairs left without strobe", sb.size(), 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (symbol_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4", "unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(edge_cnt == e.at_edge, "R3", "strobe edge", edge_cnt, e.at_edge);
                    check(q_bit == e.q, "R2", "q_bit first of pair", q_bit, e.q);
                    check(i_bit == e.i, "R2", "i_bit second of pair", i_bit, e.i);
                    check(int'(i_level) == (e.i ? 1 : -1), "R6", "i_level", int'(i_level), e.i ? 1 : -1);
                    check(int'(q_level) == (e.q ? 1 : -1), "R6", "q_level", int'(q_level), e.q ? 1 : -1);
                end
                last_i = i_bit;
                last_q = q_bit;
            end else begin
                check(i_bit == last_i && q_bit == last_q, "R5", "hold between strobes",
                      {i_bit, q_bit}, {last_i, last_q});
                check(sb.size() == 0 || edge_cnt < sb[0].at_edge, "R3", "strobe late",
                      edge_cnt, sb.size() ? sb[0].at_edge : 0);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (!done && edge_cnt > WDOG_MAX) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", edge_cnt, WDOG_MAX);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check(symbol_valid == 1'b0, "R7", "valid in reset", symbol_valid, 0);
        check(int'(i_level) == -1 && int'(q_level) == -1, "R7", "levels in reset",
              int'(i_level), -1);
        rst = 1'b0;
        last_i = 1'b0;
        last_q = 1'b0;
        @(negedge clk);

        // R1, R2: 100 pattern with gaps and bit_in noise
        send_pattern(3'b100, 4, 3);
        drain();
        // R8: 110 pattern, bit_en every cycle
        send_pattern(3'b110, 4, 0);
        drain();
        // 100 back-to-back, then 110 with long gaps
        send_pattern(3'b100, 2, 0);
        send_pattern(3'b110, 2, 5);
        drain();

        // R7: reset in the middle of a pair
        send_bit(1'b1, 1);
        rst = 1'b1;
        have_first = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(symbol_valid == 1'b0 && i_bit == 1'b0 && q_bit == 1'b0, "R7",
              "cleared after mid-pair reset", {symbol_valid, i_bit, q_bit}, 0);
        rst = 1'b0;
        last_i = 1'b0;
        last_q = 1'b0;
        @(negedge clk);
        send_bit(1'b1, 2);
        send_bit(1'b0, 2);
        drain();
        check(q_bit == 1'b1 && i_bit == 1'b0, "R7", "new pair after reset",
              {q_bit, i_bit}, 2'b10);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule